// File: doc/BRIEF.md
# Prioritised Exception Vector Controller

This block collects the eight exception request lines of a small processor core, keeps the event-type requests pending until they are serviced, and, at each instruction boundary that the core reports, picks the single most urgent eligible request. It answers with a one-cycle entry strobe, a one-hot acknowledge that names the serviced source, the handler vector address for that source, and the processor mode that the core must enter.

Five sources are one-shot events: undefined instruction, software interrupt, prefetch abort, data abort and address exception. Each one is latched on a single-cycle pulse and held until it is acknowledged. The reset request and the two interrupt lines (normal and fast) are levels. The interrupt lines are gated by two disable bits that the block owns. Taking an interrupt sets the matching disable bits. The core rewrites the bits through a simple write strobe. Saving the return address, switching register banks and running the handler are left to the core.

The vector map is fixed. Source index i has its handler at byte address 4*i in a 26-bit address space. Urgency is a separate fixed ranking that does not follow the address order.

Top module: `exc_vector_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, enter_o, ack_o and vec_o go to zero, mode_o goes to 3, and both irq_dis_o and fiq_dis_o go to 1.
- R2: A one-cycle pulse on undef_i, swi_i, pabt_i, dabt_i or addr_exc_i stays pending until that source is acknowledged. Without boundary_i nothing is acknowledged and enter_o stays 0.
- R3: At an edge with boundary_i high and at least one eligible request, exactly one source is acknowledged. ack_o is one-hot with bit index = source index (0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 address exception, 6 normal interrupt, 7 fast interrupt), and enter_o is high. Requests that lose stay pending for later boundaries.
- R4: Ranking from most to least urgent is reset, address exception, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R5: vec_o equals 4 times the index of the acknowledged source (0x00 to 0x1C).
- R6: mode_o gives the mode to enter: 1 for the fast interrupt, 2 for the normal interrupt, 3 (supervisor) for every other source, the software interrupt included.
- R7: irq_i and fiq_i are level requests. Each is ignored while its own disable bit is 1.
- R8: Taking the fast interrupt or the reset request sets both disable bits. Taking the normal interrupt sets only irq_dis_o.
- R9: When no exception is taken in that cycle, mask_wr_i loads irq_dis_o from mask_irq_i and fiq_dis_o from mask_fiq_i at the next edge.
- R10: While rst_req_i is high, every boundary acknowledges the reset source only, and all pending one-shot requests are discarded.
- R11: enter_o and ack_o are valid in the single cycle after the boundary edge and drop to 0 in the cycle after that unless another exception is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary this cycle |
| rst_req_i | input | 1 | Reset exception request (level) |
| undef_i | input | 1 | Undefined instruction event (pulse) |
| swi_i | input | 1 | Software interrupt event (pulse) |
| pabt_i | input | 1 | Prefetch abort event (pulse) |
| dabt_i | input | 1 | Data abort event (pulse) |
| addr_exc_i | input | 1 | Address exception event (pulse) |
| irq_i | input | 1 | Normal interrupt request (level) |
| fiq_i | input | 1 | Fast interrupt request (level) |
| mask_wr_i | input | 1 | Write strobe for the disable bits |
| mask_irq_i | input | 1 | New normal interrupt disable value |
| mask_fiq_i | input | 1 | New fast interrupt disable value |
| enter_o | output | 1 | Exception entry strobe |
| ack_o | output | 8 | One-hot acknowledge of the serviced source |
| vec_o | output | 26 | Handler vector address |
| mode_o | output | 2 | Mode to enter |
| irq_dis_o | output | 1 | Normal interrupt disable bit |
| fiq_dis_o | output | 1 | Fast interrupt disable bit |

## Verification
The assertions assume that the core asserts mask_wr_i only in cycles where it expects no exception entry, and that the event inputs are single-cycle pulses. A pulse that coincides with an acknowledge of the same source is absorbed by that acknowledge. The stimulus drives every input on the falling edge and returns pulses to zero after one cycle. Before each table vector it flushes leftover pending events with a reset request and then clears both disable bits with a separate write, so each vector starts from a known empty state.

// File: rtl/evc_pkg.sv
// Shared definitions for the exception vector controller.
// Source index doubles as the vector slot; urgency ranking is a separate table.
package evc_pkg;

    localparam int NSRC  = 8;
    localparam int SRC_W = 3;
    localparam int NEVT  = 5;   // one-shot sources occupy indices 1..5

    typedef enum logic [SRC_W-1:0] {
        SRC_RST  = 3'd0,
        SRC_UND  = 3'd1,
        SRC_SWI  = 3'd2,
        SRC_PABT = 3'd3,
        SRC_DABT = 3'd4,
        SRC_ADDR = 3'd5,
        SRC_IRQ  = 3'd6,
        SRC_FIQ  = 3'd7
    } src_e;

    typedef enum logic [1:0] {
        MODE_USR = 2'd0,
        MODE_FIQ = 2'd1,
        MODE_IRQ = 2'd2,
        MODE_SVC = 2'd3
    } mode_e;

    // Source index held at a given urgency rank (0 = most urgent).
    function automatic int rank_to_src(input int rank);
        case (rank)
            0:       return int'(SRC_RST);
            1:       return int'(SRC_ADDR);
            2:       return int'(SRC_DABT);
            3:       return int'(SRC_FIQ);
            4:       return int'(SRC_IRQ);
            5:       return int'(SRC_PABT);
            6:       return int'(SRC_UND);
            default: return int'(SRC_SWI);
        endcase
    endfunction

    // Mode the core enters for a given source.
    function automatic mode_e src_mode(input logic [SRC_W-1:0] s);
        if (s == SRC_FIQ)      return MODE_FIQ;
        else if (s == SRC_IRQ) return MODE_IRQ;
        else                   return MODE_SVC;
    endfunction

endpackage

// File: rtl/evc_pending.sv
// Pending latch for one-shot exception events.
// Assumes: pulse_i bits are single-cycle events; clr_i is one-hot or zero and
// only names bits currently requesting; flush_i discards all pending state.
module evc_pending #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic [W-1:0] clr_i,
    input  logic         flush_i,
    output logic [W-1:0] req_o
);

    logic [W-1:0] pend_q;

    // Hold each event until cleared by acknowledge or discarded by flush.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= '0;
        else if (flush_i) pend_q <= '0;
        else              pend_q <= (pend_q | pulse_i) & ~clr_i;
    end

    // Requests seen this cycle include a same-cycle pulse.
    always_comb begin
        req_o = flush_i ? '0 : (pend_q | pulse_i);
    end

    // R2
    evt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_i |=> (((pend_q | $past(clr_i)) & $past(pulse_i)) == $past(pulse_i)));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (pend_q == '0));

endmodule

// File: rtl/evc_arbiter.sv
// Fixed-rank arbiter: grants the most urgent active request.
// Assumes: ranking comes from evc_pkg::rank_to_src and covers every source once.
module evc_arbiter
    import evc_pkg::*;
(
    input  logic [NSRC-1:0]  req_i,
    output logic [NSRC-1:0]  gnt_o,
    output logic [SRC_W-1:0] idx_o,
    output logic             any_o
);

    logic [NSRC:0] blk;

    assign blk[0] = 1'b0;

    // One stage per rank: a request wins unless a more urgent one is active.
    for (genvar r = 0; r < NSRC; r++) begin : g_rank
        localparam int S = rank_to_src(r);
        assign gnt_o[S]  = req_i[S] & ~blk[r];
        assign blk[r+1]  = blk[r] | req_i[S];
    end

    assign any_o = blk[NSRC];

    // Encode the one-hot grant into a source index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt_o[i]) idx_o = SRC_W'(i);
        end
    end

endmodule

// File: rtl/evc_mask.sv
// Interrupt disable bits for the normal and fast interrupt lines.
// Assumes: at most one take_* is high per cycle; a take outranks a write.
module evc_mask (
    input  logic clk,
    input  logic rst_n,
    input  logic take_rst_i,
    input  logic take_fiq_i,
    input  logic take_irq_i,
    input  logic wr_i,
    input  logic wr_irq_i,
    input  logic wr_fiq_i,
    output logic irq_dis_o,
    output logic fiq_dis_o
);

    // Update disable bits on exception entry or software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_dis_o <= 1'b1;
            fiq_dis_o <= 1'b1;
        end else if (take_rst_i || take_fiq_i) begin
            irq_dis_o <= 1'b1;
            fiq_dis_o <= 1'b1;
        end else if (take_irq_i) begin
            irq_dis_o <= 1'b1;
        end else if (wr_i) begin
            irq_dis_o <= wr_irq_i;
            fiq_dis_o <= wr_fiq_i;
        end
    end

    // R8
    fiq_masks_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_fiq_i |=> (irq_dis_o && fiq_dis_o));

    // R8
    irq_keeps_fiq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq_i |=> (irq_dis_o && (fiq_dis_o == $past(fiq_dis_o))));

    // R9
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !take_rst_i && !take_fiq_i && !take_irq_i)
            |=> (irq_dis_o == $past(wr_irq_i) && fiq_dis_o == $past(wr_fiq_i)));

endmodule

// File: rtl/exc_vector_ctrl.sv
// Exception vector controller top.
// Collects eight request sources, gates interrupts by their disable bits, and
// at each instruction boundary registers the winner's acknowledge, vector and
// entry mode. Assumes boundary_i is driven by the core once per instruction.
module exc_vector_ctrl
    import evc_pkg::*;
#(
    parameter int ADDR_W    = 26,
    parameter int VEC_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              rst_req_i,
    input  logic              undef_i,
    input  logic              swi_i,
    input  logic              pabt_i,
    input  logic              dabt_i,
    input  logic              addr_exc_i,
    input  logic              irq_i,
    input  logic              fiq_i,
    input  logic              mask_wr_i,
    input  logic              mask_irq_i,
    input  logic              mask_fiq_i,
    output logic              enter_o,
    output logic [NSRC-1:0]   ack_o,
    output logic [ADDR_W-1:0] vec_o,
    output logic [1:0]        mode_o,
    output logic              irq_dis_o,
    output logic              fiq_dis_o
);

    localparam int PAD_W = ADDR_W - SRC_W - VEC_SHIFT;

    logic [NEVT-1:0]  evt_pulse;
    logic [NEVT-1:0]  evt_req;
    logic [NEVT-1:0]  evt_clr;
    logic [NSRC-1:0]  req;
    logic [NSRC-1:0]  gnt;
    logic [SRC_W-1:0] win_idx;
    logic             win_any;
    logic             take;

    assign evt_pulse = {addr_exc_i, dabt_i, pabt_i, swi_i, undef_i};

    evc_pending #(.W(NEVT)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (evt_pulse),
        .clr_i   (evt_clr),
        .flush_i (rst_req_i),
        .req_o   (evt_req)
    );

    // Assemble the eligible request vector in source-index order.
    always_comb begin
        req            = '0;
        req[SRC_RST]   = rst_req_i;
        req[SRC_ADDR:SRC_UND] = evt_req;
        req[SRC_IRQ]   = irq_i & ~irq_dis_o;
        req[SRC_FIQ]   = fiq_i & ~fiq_dis_o;
    end

    evc_arbiter u_arb (
        .req_i (req),
        .gnt_o (gnt),
        .idx_o (win_idx),
        .any_o (win_any)
    );

    assign take    = boundary_i & win_any;
    assign evt_clr = take ? gnt[SRC_ADDR:SRC_UND] : '0;

    evc_mask u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_rst_i (take & gnt[SRC_RST]),
        .take_fiq_i (take & gnt[SRC_FIQ]),
        .take_irq_i (take & gnt[SRC_IRQ]),
        .wr_i       (mask_wr_i),
        .wr_irq_i   (mask_irq_i),
        .wr_fiq_i   (mask_fiq_i),
        .irq_dis_o  (irq_dis_o),
        .fiq_dis_o  (fiq_dis_o)
    );

    // Register the entry strobe, acknowledge, vector and mode of the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enter_o <= 1'b0;
            ack_o   <= '0;
            vec_o   <= '0;
            mode_o  <= MODE_SVC;
        end else if (take) begin
            enter_o <= 1'b1;
            ack_o   <= gnt;
            vec_o   <= {{PAD_W{1'b0}}, win_idx, {VEC_SHIFT{1'b0}}};
            mode_o  <= src_mode(win_idx);
        end else begin
            enter_o <= 1'b0;
            ack_o   <= '0;
        end
    end

    // R2
    no_ack_off_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |-> $past(boundary_i));

    // R10
    reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && rst_req_i) |=> (ack_o == NSRC'(1)));

    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && irq_dis_o) |=> !ack_o[SRC_IRQ]);

    // R7
    fiq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && fiq_dis_o) |=> !ack_o[SRC_FIQ]);

    // R3
    one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_o |-> $onehot(ack_o));

    // R11
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> !enter_o);

endmodule

// File: tb/exc_vector_ctrl_tb.sv
`timescale 1ns/1ps
module exc_vector_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0;
    logic        rst_req_i = 1'b0;
    logic        undef_i = 1'b0, swi_i = 1'b0, pabt_i = 1'b0, dabt_i = 1'b0;
    logic        addr_exc_i = 1'b0, irq_i = 1'b0, fiq_i = 1'b0;
    logic        mask_wr_i = 1'b0, mask_irq_i = 1'b0, mask_fiq_i = 1'b0;
    logic        enter_o;
    logic [7:0]  ack_o;
    logic [25:0] vec_o;
    logic [1:0]  mode_o;
    logic        irq_dis_o, fiq_dis_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_vector_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .rst_req_i(rst_req_i),
        .undef_i(undef_i), .swi_i(swi_i), .pabt_i(pabt_i), .dabt_i(dabt_i),
        .addr_exc_i(addr_exc_i), .irq_i(irq_i), .fiq_i(fiq_i),
        .mask_wr_i(mask_wr_i), .mask_irq_i(mask_irq_i), .mask_fiq_i(mask_fiq_i),
        .enter_o(enter_o), .ack_o(ack_o), .vec_o(vec_o), .mode_o(mode_o),
        .irq_dis_o(irq_dis_o), .fiq_dis_o(fiq_dis_o)
    );

    // Each entry: {requests by source index, expected one-hot acknowledge}.
    localparam logic [15:0] VECS [16] = '{
        16'h0202, 16'h0404, 16'h0808, 16'h1010,
        16'h2020, 16'h4040, 16'h8080, 16'h0101,
        16'hFF01, 16'hFE20, 16'hDE10, 16'hCE80,
        16'h4E40, 16'h0E08, 16'h0602, 16'h8480
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of requests (bit i = source i) with optional boundary.
    task automatic apply(input logic bnd, input logic [7:0] src);
        boundary_i = bnd;
        rst_req_i  = src[0];
        undef_i    = src[1];
        swi_i      = src[2];
        pabt_i     = src[3];
        dabt_i     = src[4];
        addr_exc_i = src[5];
        irq_i      = src[6];
        fiq_i      = src[7];
        @(negedge clk);
        boundary_i = 1'b0; rst_req_i = 1'b0; undef_i = 1'b0; swi_i = 1'b0;
        pabt_i = 1'b0; dabt_i = 1'b0; addr_exc_i = 1'b0; irq_i = 1'b0; fiq_i = 1'b0;
    endtask

    task automatic set_mask(input logic i_dis, input logic f_dis);
        mask_wr_i = 1'b1; mask_irq_i = i_dis; mask_fiq_i = f_dis;
        @(negedge clk);
        mask_wr_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 enter", enter_o, 0);
        check("R1 ack", ack_o, 0);
        check("R1 vec", vec_o, 0);
        check("R1 mode", mode_o, 3);
        check("R1 irq_dis", irq_dis_o, 1);
        check("R1 fiq_dis", fiq_dis_o, 1);

        // R7: both interrupts masked after reset
        apply(1'b1, 8'hC0);
        check("R7 masked interrupts", enter_o, 0);

        // R2: pulse without boundary is held, then taken later
        apply(1'b0, 8'h02);
        check("R2 no boundary", enter_o, 0);
        apply(1'b0, 8'h00);
        apply(1'b1, 8'h00);
        check("R2 held ack", ack_o, 8'h02);
        check("R2 held vec", vec_o, 26'h04);

        // R3: losers drain one per boundary
        apply(1'b1, 8'h06);
        check("R3 first", ack_o, 8'h02);
        apply(1'b1, 8'h00);
        check("R3 second", ack_o, 8'h04);
        check("R6 swi mode", mode_o, 3);
        apply(1'b1, 8'h00);
        check("R3 empty", enter_o, 0);

        // R8: fast interrupt sets both bits, normal interrupt only its own
        set_mask(1'b0, 1'b0);
        apply(1'b1, 8'h80);
        check("R8 fiq ack", ack_o, 8'h80);
        check("R8 fiq irq_dis", irq_dis_o, 1);
        check("R8 fiq fiq_dis", fiq_dis_o, 1);
        set_mask(1'b0, 1'b0);
        apply(1'b1, 8'h40);
        check("R8 irq ack", ack_o, 8'h40);
        check("R8 irq irq_dis", irq_dis_o, 1);
        check("R8 irq fiq_dis", fiq_dis_o, 0);

        // R9: software writes of the disable bits
        set_mask(1'b1, 1'b0);
        check("R9 irq_dis", irq_dis_o, 1);
        check("R9 fiq_dis", fiq_dis_o, 0);
        set_mask(1'b0, 1'b1);
        check("R9 irq_dis b", irq_dis_o, 0);
        check("R9 fiq_dis b", fiq_dis_o, 1);

        // R10: reset request discards pending events and sets masks (R8)
        set_mask(1'b0, 1'b0);
        apply(1'b0, 8'h10);
        apply(1'b1, 8'h01);
        check("R10 reset ack", ack_o, 8'h01);
        check("R8 reset irq_dis", irq_dis_o, 1);
        check("R8 reset fiq_dis", fiq_dis_o, 1);
        apply(1'b1, 8'h00);
        check("R10 flushed", enter_o, 0);
        set_mask(1'b0, 1'b0);
        apply(1'b1, 8'hFF);
        check("R10 reset only", ack_o, 8'h01);
        apply(1'b1, 8'h01);
        check("R10 reset held", ack_o, 8'h01);

        // R11: strobe lasts one cycle
        apply(1'b1, 8'h20);
        check("R11 strobe", enter_o, 1);
        apply(1'b0, 8'h00);
        check("R11 drop", enter_o, 0);
        check("R11 ack drop", ack_o, 0);

        // R4 R5 R6: table of request patterns
        for (int n = 0; n < 16; n++) begin
            logic [7:0] rq;
            logic [7:0] ex;
            int         ix;
            rq = VECS[n][15:8];
            ex = VECS[n][7:0];
            ix = 0;
            for (int b = 0; b < 8; b++) if (ex[b]) ix = b;
            apply(1'b1, 8'h01);
            set_mask(1'b0, 1'b0);
            apply(1'b1, rq);
            check("R4 ack", ack_o, ex);
            check("R3 enter", enter_o, 1);
            check("R5 vec", vec_o, 26'(ix * 4));
            check("R6 mode", mode_o, (ix == 7) ? 1 : (ix == 6) ? 2 : 3);
        end

        finish_run();
    end

endmodule